// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block is the per-processor core of a vectored interrupt controller. It tracks, for every interrupt vector, whether the vector is waiting (pending), being handled (in service) and whether it arrived as a level-triggered request. It raises a single interrupt request toward the processor whenever the most urgent waiting vector outranks the current processor priority. That priority is formed from a software-written task priority and the most urgent vector already in service.

The processor claims work with an acknowledge strobe. One cycle later the block answers with one of three results. The first is the vector to service, which moves from pending to in service. The second is a programmable spurious vector, returned when the waiting vector is masked by priority. The third is an empty indication, returned when nothing is waiting or the controller is disabled. An end-of-interrupt strobe retires the most urgent in-service vector. If that vector arrived level-triggered, the block emits a one-cycle broadcast pulse carrying its number so that the interrupt sources can re-sample their lines.

Vectors are numbered 0 to 255. A larger number is more urgent. The top four bits of a vector are its priority class.

Top module: `vec_prio_resolver`

## Requirements
- R1: An arrival sets the pending bit of its vector and records its trigger kind: `arr_level`=1 marks it level-triggered and `arr_level`=0 marks it edge-triggered, replacing any earlier kind for that vector.
- R2: Among pending vectors, the one with the largest number is the one considered for delivery, including across different 32-bit groups.
- R3: `irq_out` is high only when bit 8 of the spurious-vector register (software enable) is set, at least one vector is pending, and that vector is not blocked.
- R4: `ppr_out` equals `tpr_out` when bits 7:4 of the task priority are at least the class of the highest in-service vector. Otherwise it equals that class in bits 7:4 with zeros in bits 3:0. An empty in-service set counts as class 0.
- R5: When `ppr_out` is non-zero and the class of the highest pending vector is less than or equal to bits 7:4 of `ppr_out`, the request is blocked. An acknowledge then returns bits 7:0 of the spurious-vector register with `ack_spurious`=1 and changes no state.
- R6: An acknowledge of a deliverable vector returns its number with `ack_spurious`=0 and `ack_empty`=0, clears its pending bit and sets its in-service bit.
- R7: An end-of-interrupt clears the highest in-service bit. If that vector was level-triggered, the next cycle shows `eoi_bc_valid`=1 with `eoi_bc_vector` set to the vector for exactly one cycle. With nothing in service, the strobe has no effect.
- R8: A spurious-vector register write keeps bits 8:0 of the write data and discards all higher bits, including bit 12. Level-triggered retirements therefore always broadcast.
- R9: An acknowledge while disabled or with nothing pending returns `ack_empty`=1 with `ack_vector`=0 and changes no state.
- R10: A synchronous active-high reset clears the pending, in-service and trigger sets, the task priority, the spurious-vector register and both result strobes.
- R11: `ack_valid` and the result appear in the cycle after `ack_req`. `irq_out` reflects any arrival, acknowledge, retirement or register write from the cycle after that event onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Vector arrival strobe |
| arr_vector | input | 8 | Arriving vector number |
| arr_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write value |
| svr_we | input | 1 | Spurious-vector register write strobe |
| svr_wdata | input | 32 | Spurious-vector register write value |
| ack_req | input | 1 | Acknowledge request from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Returned vector |
| ack_spurious | output | 1 | Result is the spurious vector |
| ack_empty | output | 1 | Nothing was deliverable |
| eoi_bc_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vector | output | 8 | Vector being broadcast |
| ppr_out | output | 8 | Current processor priority |
| tpr_out | output | 8 | Current task priority |
| svr_out | output | 9 | Current spurious-vector register |

## Verification
The hardest situation to reach is a blocked request that is caused by an in-service vector rather than by the task priority. It needs two vectors of the same class, one already acknowledged and still in service, and the other waiting. The stimulus builds this by queueing two vectors of one class together with one of a lower class, acknowledging the top one, and checking three things while it stays in service: `ppr_out`, the dropped request and the spurious answer. Retirements then unwind the stack in order. A related sequence raises the task priority above an in-service class to show the task priority taking over the processor priority.

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver #(
  parameter int NVEC  = 256,
  parameter int SVR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     arr_valid,
  input  logic [$clog2(NVEC)-1:0]  arr_vector,
  input  logic                     arr_level,
  input  logic                     tpr_we,
  input  logic [$clog2(NVEC)-1:0]  tpr_wdata,
  input  logic                     svr_we,
  input  logic [SVR_W-1:0]         svr_wdata,
  input  logic                     ack_req,
  input  logic                     eoi,
  output logic                     irq_out,
  output logic                     ack_valid,
  output logic [$clog2(NVEC)-1:0]  ack_vector,
  output logic                     ack_spurious,
  output logic                     ack_empty,
  output logic                     eoi_bc_valid,
  output logic [$clog2(NVEC)-1:0]  eoi_bc_vector,
  output logic [$clog2(NVEC)-1:0]  ppr_out,
  output logic [$clog2(NVEC)-1:0]  tpr_out,
  output logic [8:0]               svr_out
);
  localparam int VW    = $clog2(NVEC);
  localparam int WORDS = NVEC / 32;
  localparam int CW    = 4;

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_n, isr_n, tmr_n;
  logic [VW-1:0]   tpr_q;
  logic [8:0]      svr_q;

  function automatic logic [VW:0] find_top(input logic [NVEC-1:0] v);
    logic [WORDS-1:0] any;
    int               w;
    logic [VW:0]      res;
    logic [31:0]      word;
    w   = 0;
    res = '0;
    for (int i = 0; i < WORDS; i++) begin
      any[i] = |v[i*32 +: 32];
      if (any[i]) w = i;
    end
    word = v[w*32 +: 32];
    if (|any) begin
      for (int b = 0; b < 32; b++)
        if (word[b]) res = {1'b1, VW'(w*32 + b)};
    end
    return res;
  endfunction

  logic [VW:0]   irr_top, isr_top;
  logic          irr_has, isr_has;
  logic [VW-1:0] irr_vec, isr_vec;
  logic [CW-1:0] isr_cls, tpr_cls, ppr_cls;
  logic [VW-1:0] ppr;
  logic          enabled, blocked, deliver;

  assign irr_top = find_top(irr_q);
  assign isr_top = find_top(isr_q);
  assign irr_has = irr_top[VW];
  assign isr_has = isr_top[VW];
  assign irr_vec = irr_top[VW-1:0];
  assign isr_vec = isr_top[VW-1:0];

  assign isr_cls = isr_has ? isr_vec[VW-1 -: CW] : '0;
  assign tpr_cls = tpr_q[VW-1 -: CW];
  assign ppr     = (tpr_cls >= isr_cls) ? tpr_q : {isr_cls, {(VW-CW){1'b0}}};
  assign ppr_cls = ppr[VW-1 -: CW];

  assign enabled = svr_q[8];
  assign blocked = (ppr != '0) && (irr_vec[VW-1 -: CW] <= ppr_cls);
  assign deliver = enabled && irr_has && !blocked;

  assign irq_out = deliver;
  assign ppr_out = ppr;
  assign tpr_out = tpr_q;
  assign svr_out = svr_q;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_req && deliver) begin
      irr_n[irr_vec] = 1'b0;
      isr_n[irr_vec] = 1'b1;
    end
    if (eoi && isr_has) isr_n[isr_vec] = 1'b0;
    if (arr_valid) begin
      irr_n[arr_vector] = 1'b1;
      tmr_n[arr_vector] = arr_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q         <= '0;
      isr_q         <= '0;
      tmr_q         <= '0;
      tpr_q         <= '0;
      svr_q         <= '0;
      ack_valid     <= 1'b0;
      ack_vector    <= '0;
      ack_spurious  <= 1'b0;
      ack_empty     <= 1'b0;
      eoi_bc_valid  <= 1'b0;
      eoi_bc_vector <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (tpr_we) tpr_q <= tpr_wdata;
      if (svr_we) svr_q <= svr_wdata[8:0];
      ack_valid    <= ack_req;
      ack_spurious <= 1'b0;
      ack_empty    <= 1'b0;
      ack_vector   <= '0;
      if (ack_req) begin
        if (!enabled || !irr_has) ack_empty <= 1'b1;
        else if (blocked) begin
          ack_spurious <= 1'b1;
          ack_vector   <= svr_q[VW-1:0];
        end else ack_vector <= irr_vec;
      end
      eoi_bc_valid  <= eoi && isr_has && tmr_q[isr_vec];
      eoi_bc_vector <= isr_vec;
    end
  end

  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (rst)
    ack_valid && !ack_spurious && !ack_empty |-> isr_q[ack_vector]);
  p_ppr_floor_r4: assert property (@(posedge clk) disable iff (rst)
    ppr_out[VW-1 -: CW] >= tpr_out[VW-1 -: CW]);
  p_irq_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> svr_out[8] && (irr_q != '0));
  p_bc_retired_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_bc_valid |-> !isr_q[eoi_bc_vector]);
  p_bc_after_eoi_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_bc_valid |-> $past(eoi));
  p_svr_width_r8: assert property (@(posedge clk) disable iff (rst)
    svr_we |=> svr_out == $past(svr_wdata[8:0]));
  p_ack_latency_r11: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_valid);
endmodule

// File: tb/vec_prio_resolver_tb_top.sv
module vec_prio_resolver_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic arr_valid = 0, arr_level = 0, tpr_we = 0, svr_we = 0, ack_req = 0, eoi = 0;
  logic [7:0] arr_vector = 0, tpr_wdata = 0;
  logic [31:0] svr_wdata = 0;
  logic irq_out, ack_valid, ack_spurious, ack_empty, eoi_bc_valid;
  logic [7:0] ack_vector, eoi_bc_vector, ppr_out, tpr_out;
  logic [8:0] svr_out;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  vec_prio_resolver dut_i (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_vector(arr_vector),
    .arr_level(arr_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .svr_we(svr_we), .svr_wdata(svr_wdata), .ack_req(ack_req), .eoi(eoi),
    .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .ack_spurious(ack_spurious), .ack_empty(ack_empty),
    .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector),
    .ppr_out(ppr_out), .tpr_out(tpr_out), .svr_out(svr_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic arrive(input logic [7:0] v, input logic lvl);
    @(negedge clk); arr_valid = 1; arr_vector = v; arr_level = lvl;
    step(); @(negedge clk); arr_valid = 0;
  endtask

  task automatic set_tpr(input logic [7:0] v);
    @(negedge clk); tpr_we = 1; tpr_wdata = v;
    step(); @(negedge clk); tpr_we = 0;
  endtask

  task automatic set_svr(input logic [31:0] v);
    @(negedge clk); svr_we = 1; svr_wdata = v;
    step(); @(negedge clk); svr_we = 0;
  endtask

  // kind: 0 deliver, 1 spurious, 2 empty
  task automatic ack_expect(input int kind, input logic [7:0] v, input string req);
    @(negedge clk); ack_req = 1;
    step();
    chk(ack_valid === 1'b1, "R11", ack_valid, 1);
    chk(ack_spurious === (kind == 1) && ack_empty === (kind == 2), req,
        {ack_spurious, ack_empty}, {kind == 1, kind == 2});
    chk(ack_vector === v, req, ack_vector, v);
    @(negedge clk); ack_req = 0;
  endtask

  task automatic eoi_expect(input bit bc, input logic [7:0] v, input string req);
    @(negedge clk); eoi = 1;
    step();
    chk(eoi_bc_valid === bc, req, eoi_bc_valid, bc);
    if (bc) chk(eoi_bc_vector === v, req, eoi_bc_vector, v);
    @(negedge clk); eoi = 0;
    step();
    chk(eoi_bc_valid === 1'b0, "R7 pulse width", eoi_bc_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(posedge clk); #1;
    chk(irq_out === 0 && ppr_out === 0 && tpr_out === 0, "R10", {irq_out, ppr_out, tpr_out}, 0);
    chk(svr_out === 0 && ack_valid === 0 && eoi_bc_valid === 0, "R10", svr_out, 0);
    @(negedge clk); rst = 0;
    ack_expect(2, 8'h00, "R9 empty after reset");
  endtask

  task automatic t_enable();
    arrive(8'h40, 0);
    chk(irq_out === 0, "R3 disabled", irq_out, 0);
    ack_expect(2, 8'h00, "R9 disabled ack");
    set_svr(32'h0000_F1FF);
    chk(svr_out === 9'h1FF, "R8 width", svr_out, 9'h1FF);
    chk(irq_out === 1, "R3 enabled", irq_out, 1);
    ack_expect(0, 8'h40, "R6 deliver 0x40");
    chk(irq_out === 0, "R11 irq drops", irq_out, 0);
    eoi_expect(0, 8'h00, "R7 edge no bc");
  endtask

  task automatic t_order();
    arrive(8'h21, 0); arrive(8'h85, 0); arrive(8'h84, 0);
    ack_expect(0, 8'h85, "R2 highest");
    chk(ppr_out === 8'h80, "R4 isr class", ppr_out, 8'h80);
    chk(irq_out === 0, "R5 same class blocked", irq_out, 0);
    ack_expect(1, 8'hFF, "R5 spurious");
    chk(ppr_out === 8'h80 && irq_out === 0, "R5 no change", ppr_out, 8'h80);
    eoi_expect(0, 8'h00, "R1 edge retire");
    chk(irq_out === 1 && ppr_out === 8'h00, "R7 unblock", {irq_out, ppr_out}, 9'h100);
    ack_expect(0, 8'h84, "R2 next");
    ack_expect(1, 8'hFF, "R5 lower class");
    eoi_expect(0, 8'h00, "R7 retire 0x84");
    ack_expect(0, 8'h21, "R2 cross word");
    eoi_expect(0, 8'h00, "R7 retire 0x21");
    eoi_expect(0, 8'h00, "R7 empty isr");
    ack_expect(2, 8'h00, "R9 nothing pending");
  endtask

  task automatic t_level();
    arrive(8'h60, 1);
    ack_expect(0, 8'h60, "R6 level");
    set_svr(32'h0000_11FF);
    chk(svr_out === 9'h1FF, "R8 bit12 dropped", svr_out, 9'h1FF);
    eoi_expect(1, 8'h60, "R8 R7 level broadcast");
    arrive(8'h60, 0);
    ack_expect(0, 8'h60, "R1 rearrive");
    eoi_expect(0, 8'h00, "R1 edge overrides level");
  endtask

  task automatic t_tpr();
    set_tpr(8'h55);
    chk(ppr_out === 8'h55, "R4 tpr wins", ppr_out, 8'h55);
    arrive(8'h50, 0);
    chk(irq_out === 0, "R5 tpr blocks", irq_out, 0);
    arrive(8'h6A, 0);
    chk(irq_out === 1, "R3 above tpr", irq_out, 1);
    ack_expect(0, 8'h6A, "R6 0x6A");
    chk(ppr_out === 8'h60, "R4 isr over tpr", ppr_out, 8'h60);
    set_tpr(8'h7C);
    chk(ppr_out === 8'h7C, "R4 tpr over isr", ppr_out, 8'h7C);
    eoi_expect(0, 8'h00, "R7 retire 0x6A");
    ack_expect(1, 8'hFF, "R5 tpr spurious");
    set_tpr(8'h00);
    chk(irq_out === 1 && ppr_out === 0, "R11 tpr lowers", irq_out, 1);
    ack_expect(0, 8'h50, "R6 0x50");
    chk(ppr_out === 8'h50, "R4 low nibble zero", ppr_out, 8'h50);
    eoi_expect(0, 8'h00, "R7 retire 0x50");
    arrive(8'h05, 0);
    chk(irq_out === 1, "R5 zero ppr class0", irq_out, 1);
    ack_expect(0, 8'h05, "R6 0x05");
    chk(ppr_out === 8'h00, "R4 class0 isr", ppr_out, 0);
    eoi_expect(0, 8'h00, "R7 retire 0x05");
    arrive(8'h00, 0); arrive(8'hFF, 1);
    ack_expect(0, 8'hFF, "R2 top vector");
    eoi_expect(1, 8'hFF, "R7 level 0xFF");
    ack_expect(0, 8'h00, "R6 vector 0");
    eoi_expect(0, 8'h00, "R7 retire 0");
  endtask

  task automatic t_reset_mid();
    arrive(8'h90, 1); set_tpr(8'h30);
    @(negedge clk); rst = 1; step(); @(negedge clk); rst = 0; #1;
    chk(irq_out === 0 && tpr_out === 0 && svr_out === 0, "R10 mid reset",
        {irq_out, tpr_out, svr_out}, 0);
    set_svr(32'h100);
    chk(irq_out === 0, "R10 pending cleared", irq_out, 0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_order();
    t_level();
    t_tpr();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule